// File: doc/BRIEF.md
# Slot Interrupt Router with Mapping Autodetect

This block routes the four interrupt pins (A to D) of each device slot on a small PCI backplane onto four level-sensitive host interrupt lines. Each output line is the wired-OR of every slot pin that is routed to it. The routing normally rotates with the slot number. The amount of rotation depends on a board-variant strap.

Some older host software assumes a wrong, non-rotated wiring. To support it, the block watches configuration write traffic. It classifies the first write to a device's interrupt-line register (offset 0x3C) and settles on one of three mapping states. Once the state is resolved it cannot change until reset. A reset strap can also force the state directly.

Top module: `pci_irq_router`

## Requirements
- R1: On reset, `mapState` loads from `modeStrap`. The encoding is 0 = ASSUME_OK, 1 = BROKEN and 2 = FORCE_OK. A strap value of 3 loads ASSUME_OK.
- R2: Detection happens only on a cycle that meets all four conditions: `cfgWrEn` is high, `variantSel` is 0, the state is ASSUME_OK, and `cfgAddr[7:0]` equals 0x3C. On any other cycle, `mapState` holds its value.
- R3: The slot is taken as `cfgAddr[15:11]`, and m = slot mod 4 (`cfgAddr[12:11]`). A detecting write with value 27 gives BROKEN, except when m is 2; in that case the state stays ASSUME_OK.
- R4: A detecting write with value m+27 or m+91 gives BROKEN.
- R5: A detecting write with any value not covered by R3 or R4 gives FORCE_OK.
- R6: Once the state is BROKEN or FORCE_OK, it never changes until the next reset.
- R7: In BROKEN state, pin p of every slot drives output p.
- R8: In any other state, slot s pin p drives output (s+p+2) mod 4 when `variantSel` is 0, and output (s+p+3) mod 4 when `variantSel` is 1. Slot s uses `intIn[4*s+3:4*s]`, with pin A in bit 0.
- R9: Each output is the OR of all inputs routed to it. With no input asserted, all outputs are 0.
- R10: Routing is combinational from the current state. A state change takes effect on the outputs in the cycle after the detecting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Config write strobe (snooped) |
| cfgAddr | input | 24 | Config write address |
| cfgData | input | 32 | Config write value |
| variantSel | input | 1 | Board variant: 0 = rotate by 2 with detection, 1 = rotate by 3 |
| modeStrap | input | 2 | Mapping state loaded at reset |
| intIn | input | 4*NUM_SLOTS | Slot interrupt levels, 4 per slot |
| intOut | output | 4 | Host interrupt lines |
| mapState | output | 2 | Current mapping state |

## Verification
A detecting configuration write can land in the same cycle as asserted interrupt levels. The bench drives that collision deliberately. It holds interrupt levels steady across the write that turns the state to BROKEN. It then checks that the outputs still show the old rotated routing in the write's own cycle and show the direct routing in the next cycle. A behavioural model in the bench, advanced on each clock, judges every cycle, including writes that must be ignored because of the offset, the variant or stickiness.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    MAP_ASSUME = 2'd0,
    MAP_BROKEN = 2'd1,
    MAP_FORCE  = 2'd2
  } map_state_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       passThru;
    logic [1:0] rotate;
  } route_ctl_t;

  localparam logic [7:0] INT_LINE_OFS = 8'h3C;
  localparam int LEGACY_BASE = 27;
  localparam int LEGACY_HIGH = 91;
endpackage

// File: rtl/irq_map_detect.sv
module irq_map_detect
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              variantSel,
  input  logic [1:0]        modeStrap,
  output route_ctl_t        routeCtl,
  output logic [1:0]        mapState
);
  map_state_e stateQ, stateNext, verdict, resetState;
  logic [1:0] slotMod;
  logic       detectHit;

  assign slotMod   = cfgAddr[12:11];
  assign detectHit = cfgWrEn && !variantSel && (stateQ == MAP_ASSUME)
                     && (cfgAddr[7:0] == INT_LINE_OFS);

  always_comb begin
    if (cfgData == DATA_W'(LEGACY_BASE))
      verdict = (slotMod == 2'd2) ? MAP_ASSUME : MAP_BROKEN;
    else if (cfgData == DATA_W'(LEGACY_BASE + int'(slotMod)) ||
             cfgData == DATA_W'(LEGACY_HIGH + int'(slotMod)))
      verdict = MAP_BROKEN;
    else
      verdict = MAP_FORCE;
  end

  assign stateNext = detectHit ? verdict : stateQ;

  always_comb begin
    case (modeStrap)
      2'd1:    resetState = MAP_BROKEN;
      2'd2:    resetState = MAP_FORCE;
      default: resetState = MAP_ASSUME;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= resetState;
    else       stateQ <= stateNext;
  end

  assign routeCtl.passThru = (stateQ == MAP_BROKEN);
  assign routeCtl.rotate   = variantSel ? 2'd3 : 2'd2;
  assign mapState          = stateQ;
endmodule

// File: rtl/irq_swizzle_path.sv
module irq_swizzle_path
  import irq_route_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  route_ctl_t               routeCtl,
  input  logic [4*NUM_SLOTS-1:0]   intIn,
  output logic [3:0]               intOut
);
  logic [1:0] dest;

  always_comb begin
    intOut = '0;
    dest   = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < 4; p++) begin
        if (routeCtl.passThru)
          dest = 2'(p);
        else
          dest = 2'(s + p + int'(routeCtl.rotate));
        intOut[dest] = intOut[dest] | intIn[4*s+p];
      end
    end
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [DATA_W-1:0]      cfgData,
  input  logic                   variantSel,
  input  logic [1:0]             modeStrap,
  input  logic [4*NUM_SLOTS-1:0] intIn,
  output logic [3:0]             intOut,
  output logic [1:0]             mapState
);
  route_ctl_t routeCtl;

  irq_map_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_detect (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .variantSel(variantSel), .modeStrap(modeStrap),
    .routeCtl(routeCtl), .mapState(mapState)
  );

  irq_swizzle_path #(.NUM_SLOTS(NUM_SLOTS)) u_path (
    .routeCtl(routeCtl), .intIn(intIn), .intOut(intOut)
  );
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cfgWrEn,
  input logic                   variantSel,
  input logic [4*NUM_SLOTS-1:0] intIn,
  input logic [3:0]             intOut,
  input logic [1:0]             mapState
);
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    mapState != 2'd3);
  p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(mapState));
  p_variant_no_detect_r2: assert property (@(posedge clk) disable iff (!rstN)
    (variantSel && mapState == 2'd0) |=> mapState == 2'd0);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mapState != 2'd0) |=> $stable(mapState));
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intIn == '0) |-> (intOut == 4'd0));
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(intOut) <= $countones(intIn));
endmodule

bind pci_irq_router pci_irq_router_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .variantSel(variantSel),
  .intIn(intIn), .intOut(intOut), .mapState(mapState)
);

// File: tb/tb_pci_irq_router.sv
module tb_pci_irq_router;
  localparam int NS = 4;
  logic clk = 0, rstN = 0, cfgWrEn = 0, variantSel = 0;
  logic [23:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [1:0]  modeStrap = '0;
  logic [4*NS-1:0] intIn = '0;
  logic [3:0] intOut;
  logic [1:0] mapState;
  int nRun = 0, nFail = 0;
  int mState = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NS)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .variantSel(variantSel), .modeStrap(modeStrap),
    .intIn(intIn), .intOut(intOut), .mapState(mapState)
  );

  function automatic logic [3:0] refRoute(int st, bit v, logic [4*NS-1:0] ins);
    logic [3:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (ins[4*s+p]) r[(st == 1) ? p : ((s + p + (v ? 3 : 2)) % 4)] = 1'b1;
    return r;
  endfunction

  task automatic compare(string tag);
    logic [3:0] expOut = refRoute(mState, variantSel, intIn);
    nRun++;
    if (mapState !== 2'(mState)) begin
      nFail++;
      $display("FAIL %s mapState actual=%0d expected=%0d", tag, mapState, mState);
    end
    nRun++;
    if (intOut !== expOut) begin
      nFail++;
      $display("FAIL %s intOut actual=%b expected=%b", tag, intOut, expOut);
    end
  endtask

  // one cycle: drive at negedge, check, then model advances at posedge
  task automatic step(bit en, logic [23:0] a, logic [31:0] d,
                      logic [4*NS-1:0] ins, string tag);
    @(negedge clk);
    cfgWrEn = en; cfgAddr = a; cfgData = d; intIn = ins;
    #2 compare(tag);
    @(posedge clk);
    if (en && !variantSel && mState == 0 && a[7:0] == 8'h3C) begin
      int m = int'(a[12:11]);
      if (d == 27) mState = (m == 2) ? 0 : 1;
      else if (d == 32'(m + 27) || d == 32'(m + 91)) mState = 1;
      else mState = 2;
    end
  endtask

  task automatic doReset(logic [1:0] strap, bit v, string tag);
    @(negedge clk);
    rstN = 0; modeStrap = strap; variantSel = v; cfgWrEn = 0; intIn = '0;
    mState = (strap == 2'd1) ? 1 : (strap == 2'd2) ? 2 : 0;
    #2 compare(tag);
    @(negedge clk);
    rstN = 1;
  endtask

  function automatic logic [23:0] lineAddr(int slot);
    return 24'((slot << 11) | 8'h3C);
  endfunction

  initial begin
    doReset(2'd0, 0, "R1 reset assume");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 16'(1 << i), "R8 variant0 single pin");
    step(0, 0, 0, 16'h0000, "R9 all quiet");
    step(0, 0, 0, 16'h0024, "R9 two inputs same output");
    step(1, lineAddr(2), 27, 16'h0001, "R3 value 27 slot2 stays");
    step(1, 24'h00003D, 77, 16'h0010, "R2 wrong offset ignored");
    step(0, lineAddr(1), 50, 16'h0100, "R2 no strobe ignored");
    step(1, lineAddr(1), 92, 16'h0102, "R4 R10 write with levels held");
    step(0, 0, 0, 16'h0102, "R10 reroute next cycle");
    step(1, lineAddr(0), 55, 16'h0102, "R6 broken sticky");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 16'(1 << i), "R7 passthrough pin");
    doReset(2'd0, 0, "R1 reset again");
    step(1, lineAddr(3), 50, 16'h1000, "R5 other value force");
    step(1, lineAddr(3), 27, 16'h1000, "R6 force sticky");
    step(0, 0, 0, 16'hA5A5, "R9 multi force");
    doReset(2'd0, 0, "R1 reset slot3");
    step(1, lineAddr(3), 94, 0, "R4 high offset value");
    step(0, 0, 0, 16'h0008, "R7 after high offset");
    doReset(2'd0, 0, "R1 reset slot0");
    step(1, lineAddr(4), 27, 0, "R3 value 27 slot4 broken");
    step(0, 0, 0, 16'hFFFF, "R7 all pins");
    doReset(2'd0, 1, "R1 reset variant1");
    step(1, lineAddr(1), 27, 16'h0001, "R2 variant1 no detect");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 16'(1 << i), "R8 variant1 single pin");
    doReset(2'd1, 0, "R1 strap broken");
    step(1, lineAddr(1), 50, 16'h0040, "R6 strap broken sticky");
    doReset(2'd2, 0, "R1 strap force");
    step(1, lineAddr(1), 28, 16'h0040, "R6 strap force sticky");
    doReset(2'd3, 0, "R1 strap 3 assume");
    for (int i = 0; i < 40; i++)
      step(($urandom % 4) == 0, lineAddr(int'($urandom % 32)),
           32'(($urandom % 3 == 0) ? 27 + ($urandom % 4) : ($urandom % 100)),
           16'($urandom), "R9 random mix");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); nRun++; nFail++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule